// File: doc/BRIEF.md
# Multi-Mode ADC Channel Sequencer

This block sits between software control and a successive-approximation conversion engine. It decides which of eight analog channels the engine converts next, in what order, and whether the sequence runs once or loops. It does this according to one of five operating modes. A conversion sequence starts in one of two ways. With the software trigger source, it starts when the start flag rises. With the external trigger source, it starts on a falling edge of an active-low trigger pin, and only while the start flag is set. In external mode, a fresh falling edge aborts the conversion in progress and begins the sequence again.

Every completed result is written into a per-channel result register. Each register is read as two bytes: the even byte address holds the low eight bits and the odd byte address holds the upper bits. A one-cycle completion pulse marks each stored result. The engine itself is outside the block: the sequencer issues a start pulse with a channel number, and it accepts a done pulse carrying the result.

Top module: `adc_seq`

## Requirements
- R1: Mode 0 (single conversion) converts the channel on `chan_sel_i` once, then clears the start flag and stays idle.
- R2: Mode 1 (channel loop) converts the `chan_sel_i` channel repeatedly. Once the start flag is cleared, the conversion already in flight completes and no further conversion starts.
- R3: Mode 2 (group pass) converts channels 0 up to 2*`grp_sel_i`+1 in ascending order once, then clears the start flag.
- R4: Mode 3 (group loop) converts the same group as mode 2 in ascending order, wrapping to channel 0 after the last member, until the start flag is cleared.
- R5: Mode 4 (interleaved group loop) alternates the priority channel `chan_sel_i` with successive group members: priority, 0, priority, 1, and so on, wrapping after the last member.
- R6: With `ext_trig_en_i` low, a sequence starts on a 0-to-1 transition of the start flag. With `ext_trig_en_i` high, setting the flag starts nothing.
- R7: With `ext_trig_en_i` high, a high-to-low transition of `ext_trig_n_i`, taken after a two-stage synchronizer, starts a sequence only while the start flag is 1. With the flag at 0 the edge is ignored.
- R8: An external falling edge that arrives while a conversion is in flight raises `eng_abort_o` together with a new `eng_start_o`. The engine's result for the aborted conversion is discarded, and the sequence restarts from its first channel.
- R9: With `res10_i` high, the result's bits 7:0 go to byte address 2*ch and its bits 9:8 go to bits 1:0 of byte address 2*ch+1, whose upper bits read 0.
- R10: With `res10_i` low, only byte address 2*ch is written, with result bits 7:0, and the odd byte keeps its previous content.
- R11: `done_o` pulses for exactly one cycle for each stored result, in the cycle its register first holds the new value.
- R12: After reset, no engine start is issued, the start flag is 0, and all result bytes read 0. `rd_data_o` follows `rd_addr_i` with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Operating mode 0..4 |
| chan_sel_i | input | 3 | Channel for modes 0/1, priority channel for mode 4 |
| grp_sel_i | input | 2 | Group size select, group = channels 0..2*n+1 |
| ext_trig_en_i | input | 1 | 1 selects the external trigger source |
| ext_trig_n_i | input | 1 | Asynchronous active-low external trigger |
| res10_i | input | 1 | 1 selects 10-bit storage, 0 selects 8-bit |
| flag_set_i | input | 1 | Set the start flag |
| flag_clr_i | input | 1 | Clear the start flag (wins over set) |
| eng_done_i | input | 1 | Engine conversion finished |
| eng_result_i | input | 10 | Engine result |
| eng_start_o | output | 1 | Engine start pulse |
| eng_abort_o | output | 1 | Abort of the conversion in flight |
| eng_chan_o | output | 3 | Channel being converted |
| start_flag_o | output | 1 | Current start flag |
| done_o | output | 1 | Result stored pulse |
| rd_addr_i | input | 4 | Result byte address |
| rd_data_o | output | 8 | Result byte read data |

## Verification
The bench builds the block with its default eight channels and a 10-bit result. The 2-bit group select therefore reaches every group size up to a full eight-channel sweep, and the odd byte carries exactly two meaningful bits. The engine model answers six cycles after each start. This is short enough that a restart edge can be placed inside a conversion in flight, and that loops can be stopped just after a chosen number of results.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    MD_ONCE       = 3'd0,
    MD_REPEAT     = 3'd1,
    MD_SWEEP      = 3'd2,
    MD_SWEEP_LOOP = 3'd3,
    MD_SWEEP_PRIO = 3'd4
  } adc_mode_e;
endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_n_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], trig_n_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = last_q & ~sync_q[STAGES-1];

  // R7: a detected edge lasts one cycle only
  a_r7_fall_single: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int RES_W = 10,
  localparam int CH_W  = $clog2(NCH),
  localparam int GRP_W = CH_W - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode_i,
  input  logic [CH_W-1:0]  chan_sel_i,
  input  logic [GRP_W-1:0] grp_sel_i,
  input  logic             ext_en_i,
  input  logic             ext_fall_i,
  input  logic             flag_set_i,
  input  logic             flag_clr_i,
  input  logic             res10_i,
  input  logic             eng_done_i,
  input  logic [RES_W-1:0] eng_result_i,
  output logic             eng_start_o,
  output logic             eng_abort_o,
  output logic [CH_W-1:0]  eng_chan_o,
  output logic             flag_o,
  output logic             wr_en_o,
  output logic [CH_W-1:0]  wr_ch_o,
  output logic [RES_W-1:0] wr_data_o,
  output logic             wr_hi_o
);
  adc_mode_e       mode;
  logic            busy_q, flag_d_q, phase_q;
  logic [CH_W-1:0] pos_q, last_pos, pos_inc;
  logic            start_evt;
  logic [CH_W-1:0] first_ch;
  logic            nxt_go, nxt_clear, nxt_phase;
  logic [CH_W-1:0] nxt_ch, nxt_pos;

  assign mode     = adc_mode_e'(mode_i);
  assign last_pos = {grp_sel_i, 1'b1};
  assign pos_inc  = (pos_q == last_pos) ? '0 : pos_q + 1'b1;

  assign start_evt = ext_en_i ? (ext_fall_i & flag_o) : (flag_o & ~flag_d_q);

  always_comb begin
    case (mode)
      MD_SWEEP, MD_SWEEP_LOOP: first_ch = '0;
      default:                 first_ch = chan_sel_i;
    endcase
  end

  always_comb begin
    nxt_go    = 1'b0;
    nxt_clear = 1'b0;
    nxt_ch    = chan_sel_i;
    nxt_pos   = pos_q;
    nxt_phase = phase_q;
    case (mode)
      MD_ONCE: nxt_clear = 1'b1;
      MD_REPEAT: nxt_go = flag_o;
      MD_SWEEP: begin
        if (pos_q == last_pos) begin
          nxt_clear = 1'b1;
        end else begin
          nxt_go  = flag_o;
          nxt_pos = pos_q + 1'b1;
          nxt_ch  = pos_q + 1'b1;
        end
      end
      MD_SWEEP_LOOP: begin
        nxt_go  = flag_o;
        nxt_pos = pos_inc;
        nxt_ch  = pos_inc;
      end
      MD_SWEEP_PRIO: begin
        nxt_go = flag_o;
        if (!phase_q) begin
          nxt_ch    = pos_q;
          nxt_phase = 1'b1;
        end else begin
          nxt_ch    = chan_sel_i;
          nxt_phase = 1'b0;
          nxt_pos   = pos_inc;
        end
      end
      default: nxt_clear = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      flag_o      <= 1'b0;
      flag_d_q    <= 1'b0;
      phase_q     <= 1'b0;
      pos_q       <= '0;
      eng_start_o <= 1'b0;
      eng_abort_o <= 1'b0;
      eng_chan_o  <= '0;
      wr_en_o     <= 1'b0;
      wr_ch_o     <= '0;
      wr_data_o   <= '0;
      wr_hi_o     <= 1'b0;
    end else begin
      eng_start_o <= 1'b0;
      eng_abort_o <= 1'b0;
      wr_en_o     <= 1'b0;
      flag_d_q    <= flag_o;
      if (flag_clr_i)      flag_o <= 1'b0;
      else if (flag_set_i) flag_o <= 1'b1;
      if (start_evt) begin
        busy_q      <= 1'b1;
        pos_q       <= '0;
        phase_q     <= 1'b0;
        eng_start_o <= 1'b1;
        eng_abort_o <= busy_q;
        eng_chan_o  <= first_ch;
      end else if (busy_q && eng_done_i) begin
        wr_en_o   <= 1'b1;
        wr_ch_o   <= eng_chan_o;
        wr_data_o <= eng_result_i;
        wr_hi_o   <= res10_i;
        if (nxt_go) begin
          eng_start_o <= 1'b1;
          eng_chan_o  <= nxt_ch;
          pos_q       <= nxt_pos;
          phase_q     <= nxt_phase;
        end else begin
          busy_q <= 1'b0;
        end
        if (nxt_clear) flag_o <= 1'b0;
      end
    end
  end

  // R8: an abort always comes with the restart
  a_r8_abort_with_start: assert property (@(posedge clk) disable iff (rst)
    eng_abort_o |-> eng_start_o);
  // R11: a store follows an engine done while busy
  a_r11_store_after_done: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> $past(eng_done_i && busy_q));
  // R6: no start without the flag set
  a_r6_start_needs_flag: assert property (@(posedge clk) disable iff (rst)
    eng_start_o |-> $past(flag_o));
  // R1: single conversion leaves the flag clear
  a_r1_once_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && !eng_start_o && $past(mode == MD_ONCE) && !$past(flag_set_i)) |-> !flag_o);
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs #(
  parameter int NCH   = 8,
  parameter int RES_W = 10,
  localparam int CH_W = $clog2(NCH),
  localparam int HI_W = RES_W - 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [CH_W-1:0]  wr_ch_i,
  input  logic [RES_W-1:0] wr_data_i,
  input  logic             wr_hi_i,
  input  logic [CH_W:0]    rd_addr_i,
  output logic [7:0]       rd_data_o,
  output logic             done_o
);
  logic [7:0]      lo_q [NCH];
  logic [HI_W-1:0] hi_q [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q[g] <= '0;
        hi_q[g] <= '0;
      end else if (wr_en_i && wr_ch_i == CH_W'(g)) begin
        lo_q[g] <= wr_data_i[7:0];
        if (wr_hi_i) hi_q[g] <= wr_data_i[RES_W-1:8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= wr_en_i;
      if (rd_addr_i[0]) rd_data_o <= 8'(hi_q[rd_addr_i[CH_W:1]]);
      else              rd_data_o <= lo_q[rd_addr_i[CH_W:1]];
    end
  end

  // R10: an 8-bit store leaves the odd byte untouched
  a_r10_odd_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !wr_hi_i) |=> (hi_q[$past(wr_ch_i)] == $past(hi_q[wr_ch_i])));
  // R11: completion is a single-cycle pulse per store
  a_r11_done_tracks_store: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(wr_en_i));
endmodule

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int NCH   = 8,
  parameter int RES_W = 10,
  localparam int CH_W  = $clog2(NCH),
  localparam int GRP_W = CH_W - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode_i,
  input  logic [CH_W-1:0]  chan_sel_i,
  input  logic [GRP_W-1:0] grp_sel_i,
  input  logic             ext_trig_en_i,
  input  logic             ext_trig_n_i,
  input  logic             res10_i,
  input  logic             flag_set_i,
  input  logic             flag_clr_i,
  input  logic             eng_done_i,
  input  logic [RES_W-1:0] eng_result_i,
  output logic             eng_start_o,
  output logic             eng_abort_o,
  output logic [CH_W-1:0]  eng_chan_o,
  output logic             start_flag_o,
  output logic             done_o,
  input  logic [CH_W:0]    rd_addr_i,
  output logic [7:0]       rd_data_o
);
  logic             ext_fall;
  logic             wr_en, wr_hi;
  logic [CH_W-1:0]  wr_ch;
  logic [RES_W-1:0] wr_data;

  adc_trig_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .trig_n_i(ext_trig_n_i), .fall_o(ext_fall)
  );

  adc_seq_ctrl #(.NCH(NCH), .RES_W(RES_W)) u_ctrl (
    .clk(clk), .rst(rst), .mode_i(mode_i), .chan_sel_i(chan_sel_i),
    .grp_sel_i(grp_sel_i), .ext_en_i(ext_trig_en_i), .ext_fall_i(ext_fall),
    .flag_set_i(flag_set_i), .flag_clr_i(flag_clr_i), .res10_i(res10_i),
    .eng_done_i(eng_done_i), .eng_result_i(eng_result_i),
    .eng_start_o(eng_start_o), .eng_abort_o(eng_abort_o),
    .eng_chan_o(eng_chan_o), .flag_o(start_flag_o),
    .wr_en_o(wr_en), .wr_ch_o(wr_ch), .wr_data_o(wr_data), .wr_hi_o(wr_hi)
  );

  adc_result_regs #(.NCH(NCH), .RES_W(RES_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_ch_i(wr_ch),
    .wr_data_i(wr_data), .wr_hi_i(wr_hi), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .done_o(done_o)
  );
endmodule

// File: tb/adc_seq_tb_top.sv
module adc_seq_tb_top;
  localparam int LAT = 6;

  logic       clk = 0;
  logic       rst = 1;
  logic [2:0] mode = 0;
  logic [2:0] chan_sel = 0;
  logic [1:0] grp_sel = 0;
  logic       ext_en = 0, trig_n = 1, res10 = 1;
  logic       fset = 0, fclr = 0;
  logic       eng_done = 0;
  logic [9:0] eng_result = 0;
  logic       eng_start, eng_abort, start_flag, done;
  logic [2:0] eng_chan;
  logic [3:0] rd_addr = 0;
  logic [7:0] rd_data;

  int checks = 0, errors = 0;
  int starts = 0, aborts = 0, dones = 0;
  int exp_q[$];
  logic [7:0] exp_lo [8];
  logic [1:0] exp_hi [8];
  logic       m_busy = 0;
  int         m_cnt = 0;
  logic [2:0] m_ch = 0;
  logic [6:0] serial = 1;
  bit         finished = 0;
  int         cyc = 0;

  always #2.5 clk = ~clk;

  adc_seq dut_i (
    .clk(clk), .rst(rst), .mode_i(mode), .chan_sel_i(chan_sel), .grp_sel_i(grp_sel),
    .ext_trig_en_i(ext_en), .ext_trig_n_i(trig_n), .res10_i(res10),
    .flag_set_i(fset), .flag_clr_i(fclr), .eng_done_i(eng_done),
    .eng_result_i(eng_result), .eng_start_o(eng_start), .eng_abort_o(eng_abort),
    .eng_chan_o(eng_chan), .start_flag_o(start_flag), .done_o(done),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  // engine model, also keeps the expected register contents
  always @(posedge clk) begin
    eng_done <= 1'b0;
    if (rst) begin
      m_busy <= 1'b0;
      for (int i = 0; i < 8; i++) begin exp_lo[i] <= 0; exp_hi[i] <= 0; end
    end else if (eng_start) begin
      m_busy <= 1'b1;
      m_cnt  <= LAT;
      m_ch   <= eng_chan;
    end else if (m_busy) begin
      if (m_cnt == 1) begin
        eng_done   <= 1'b1;
        eng_result <= {m_ch, serial};
        exp_lo[m_ch] <= {serial[4:0], 3'b0} | {5'b0, m_ch};
        exp_lo[m_ch] <= 8'({m_ch, serial});
        if (res10) exp_hi[m_ch] <= m_ch[2:1];
        serial <= serial + 1;
        m_busy <= 1'b0;
      end else m_cnt <= m_cnt - 1;
    end
  end

  // monitor: scoreboard on channel order
  always @(negedge clk) begin
    if (!rst) begin
      if (eng_start) begin
        starts++;
        if (eng_abort) aborts++;
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R1-order: unexpected start ch actual %0d expected none", eng_chan);
        end else begin
          int e;
          e = exp_q.pop_front();
          if (int'(eng_chan) != e) begin
            errors++;
            $display("FAIL R5 sequence: channel actual %0d expected %0d", eng_chan, e);
          end
        end
      end
      if (done) dones++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_set();
    fset = 1; @(negedge clk); fset = 0;
  endtask

  task automatic pulse_clr();
    fclr = 1; @(negedge clk); fclr = 0;
  endtask

  task automatic wait_dones(input int n);
    for (int i = 0; i < 2000 && dones < n; i++) @(negedge clk);
  endtask

  task automatic rd_byte(input int a, output int v);
    rd_addr = 4'(a);
    cycles(2);
    v = int'(rd_data);
  endtask

  task automatic fall_trig();
    trig_n = 0; cycles(4); trig_n = 1;
  endtask

  initial begin
    int v, s0, d0;
    cycles(3);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk("R12 start idle", int'(eng_start), 0);
    chk("R12 flag", int'(start_flag), 0);
    rd_byte(7, v); chk("R12 byte zero", v, 0);

    // R1 single conversion, R9 10-bit layout
    mode = 0; chan_sel = 5; res10 = 1;
    exp_q.push_back(5);
    s0 = starts; d0 = dones;
    pulse_set();                          // R6 software trigger
    wait_dones(d0 + 1); cycles(20);
    chk("R1 one start", starts - s0, 1);
    chk("R11 one done", dones - d0, 1);
    chk("R1 flag cleared", int'(start_flag), 0);
    rd_byte(10, v); chk("R9 even byte", v, int'(exp_lo[5]));
    rd_byte(11, v); chk("R9 odd byte", v, int'(exp_hi[5]));

    // R10 8-bit keeps odd byte
    begin
      int old_hi;
      old_hi = int'(exp_hi[5]);
      res10 = 0; exp_q.push_back(5);
      pulse_set(); wait_dones(dones + 1); cycles(10);
      rd_byte(10, v); chk("R10 even written", v, int'(exp_lo[5]));
      rd_byte(11, v); chk("R10 odd kept", v, old_hi);
      res10 = 1;
    end

    // R2 channel loop
    mode = 1; chan_sel = 3;
    for (int i = 0; i < 5; i++) exp_q.push_back(3);
    s0 = starts; d0 = dones;
    pulse_set(); wait_dones(d0 + 4); pulse_clr(); cycles(30);
    chk("R2 starts", starts - s0, 5);
    chk("R2 dones", dones - d0, 5);

    // R3 group pass of four
    mode = 2; grp_sel = 1;
    for (int i = 0; i < 4; i++) exp_q.push_back(i);
    s0 = starts;
    pulse_set(); cycles(60);
    chk("R3 starts", starts - s0, 4);
    chk("R3 flag cleared", int'(start_flag), 0);
    rd_byte(4, v); chk("R3 ch2 even", v, int'(exp_lo[2]));

    // R4 group loop of two
    mode = 3; grp_sel = 0;
    exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(0); exp_q.push_back(1);
    s0 = starts; d0 = dones;
    pulse_set(); wait_dones(d0 + 3); pulse_clr(); cycles(30);
    chk("R4 starts", starts - s0, 4);

    // R5 interleaved loop, priority 6, group of four
    mode = 4; grp_sel = 1; chan_sel = 6;
    for (int i = 0; i < 5; i++) begin exp_q.push_back(6); exp_q.push_back(i % 4); end
    s0 = starts; d0 = dones;
    pulse_set(); wait_dones(d0 + 9); pulse_clr(); cycles(30);
    chk("R5 starts", starts - s0, 10);
    chk("R5 queue drained", exp_q.size(), 0);

    // R7 external trigger ignored without flag; R6 flag alone starts nothing
    ext_en = 1; mode = 0; chan_sel = 4;
    s0 = starts;
    fall_trig(); cycles(10);
    chk("R7 no start flag low", starts - s0, 0);
    pulse_set(); cycles(10);
    chk("R6 flag in ext mode", starts - s0, 0);
    exp_q.push_back(4);
    fall_trig(); cycles(30);
    chk("R7 ext start", starts - s0, 1);
    chk("R7 flag cleared", int'(start_flag), 0);

    // R8 retrigger restarts the group loop
    mode = 3; grp_sel = 3;
    exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(2);
    exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(2);
    s0 = starts; d0 = aborts;
    pulse_set(); fall_trig();
    wait_dones(dones + 2);
    trig_n = 0; cycles(4); trig_n = 1;
    wait_dones(dones + 2); pulse_clr(); cycles(30);
    chk("R8 aborts", aborts - d0, 1);
    chk("R8 starts", starts - s0, 6);
    chk("R8 queue drained", exp_q.size(), 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule